// File: doc/BRIEF.md
# Memory-Mapped Event Counter Bank

This block is a performance-monitoring counter bank. Software reaches it through single-cycle 32-bit register reads and writes. It holds `NUM_CTR` general event counters and an optional free-running cycle counter. Each general counter increments on clock edges where its bit of the event input vector is high. Every counter has a type register and a filter register that software can read back. These values are held for the event-selection logic next to the bank.

Three state bitmaps share one layout. They are the count-enable, interrupt-enable and overflow bitmaps. In each, bit `i` belongs to general counter `i` and bit 31 belongs to the cycle counter. Every bitmap has a write-one-to-set address and a write-one-to-clear address, and both addresses read back the same state.

A control register starts and stops all counting. It also issues one-shot clear commands, one for the general counters and one for the cycle counter. A read-only configuration word describes the build. A counter that wraps past all-ones latches an overflow flag. When that flag's interrupt enable is set, the flag raises the interrupt output.

Top module: `perf_counter_bank`

## Requirements
- R1: Offset 0xE00 reads a fixed configuration word. Bits [7:0] hold (NUM_CTR + HAS_CYC − 1), bits [13:8] hold CTR_W − 1, bit 14 is set when the cycle counter exists, and all other bits are 0.
- R2: Offset 0xE08 reads the ID_VAL parameter.
- R3: The type register of general counter i is at 0x400 + 4·i. Its filter register is at 0xA00 + 4·i. The cycle-counter filter is at 0x47C. All of them read back what was written. An index at or above NUM_CTR reads 0, and writes to it are ignored.
- R4: Bitmaps live at these offsets: count-enable set 0xC00 and clear 0xC20, interrupt-enable set 0xC40 and clear 0xC60, overflow clear 0xC80 and set 0xCC0. Bit i maps to counter i and bit 31 to the cycle counter. Writing a 1 sets or clears that bit, and writing 0 leaves it unchanged. Both addresses of a pair read the current state. Bits with no counter behind them read 0.
- R5: A general counter advances by one on each clock edge where three conditions hold together: the control enable (bit 0 of 0xE04), its count-enable bit, and its event input. Without all three it holds its value.
- R6: The cycle counter advances by one on every clock edge where the control enable and count-enable bit 31 are both set.
- R7: Counter i sits at 4·i when CTR_W ≤ 32. When CTR_W > 32 it sits at 8·i, low word first. The cycle counter uses index 31. Counters are writable and read back what was written.
- R8: A counter that advances from all-ones wraps to 0 and sets its overflow bit.
- R9: Reading 0xC80 or 0xCC0 has no side effects. When a counter wrap and a clear write hit the same overflow bit in the same cycle, the bit stays set.
- R10: irq_o is registered. It equals the OR over all counters of (overflow AND interrupt-enable), one cycle after that state changes.
- R11: Writing bit 1 of 0xE04 clears the general counters, and writing bit 2 clears the cycle counter. Neither bit is stored, so 0xE04 reads back only bit 0. Writing 0 stops all counting.
- R12: Read data and bus_rvalid appear one cycle after a read request. Unmapped offsets read 0.
- R13: After reset, every counter, bitmap and control bit is 0, and irq_o and bus_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| evt_in | input | NUM_CTR | Event pulse per general counter |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Some faults show up at once. A wrong count-enable or overflow bit is visible on the next read of either address of its set/clear pair. A bit lost in the overflow or interrupt-enable bitmaps shows on irq_o exactly one cycle later.

A gating fault in a counter shows up more slowly. It stays hidden until software reads that counter. By then the whole random window has added up in the count, so a single read exposes a miscount of even one edge. A wrap that fails to latch shows twice: as a missing irq_o two edges after the wrapping event, and as a zero overflow flag.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam logic [11:0] A_CCFILT    = 12'h47C;
  localparam logic [11:0] A_CNTEN_SET = 12'hC00;
  localparam logic [11:0] A_CNTEN_CLR = 12'hC20;
  localparam logic [11:0] A_INTEN_SET = 12'hC40;
  localparam logic [11:0] A_INTEN_CLR = 12'hC60;
  localparam logic [11:0] A_OVF_CLR   = 12'hC80;
  localparam logic [11:0] A_OVF_SET   = 12'hCC0;
  localparam logic [11:0] A_CFG       = 12'hE00;
  localparam logic [11:0] A_CTRL      = 12'hE04;
  localparam logic [11:0] A_ID        = 12'hE08;
  localparam int          CYC_IDX     = 31;
  localparam int          MAP_W       = 32;

  // control register write fields
  typedef struct packed {
    logic clr_cyc;
    logic clr_evt;
    logic run;
  } ctrl_wr_t;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         wr_en,
  input  logic         wr_hi,
  input  logic [31:0]  wr_data,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [63:0] merged;

  // replace the addressed 32-bit word of the count
  always_comb begin
    merged = 64'(cnt);
    if (wr_hi) merged[63:32] = wr_data;
    else       merged[31:0]  = wr_data;
  end

  // a bus write or a clear overrides the increment, so no wrap then
  assign wrap = inc & ~wr_en & ~clr & (&cnt);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (wr_en)  cnt <= merged[W-1:0];
    else if (inc)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pcb_bitmap.sv
module pcb_bitmap #(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_bits, set_bits;

  assign clr_bits = clr_we ? wdata : '0;
  assign set_bits = set_we ? wdata : '0;

  // hardware set is applied after software clear: a same-cycle event wins
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((q & ~clr_bits) | set_bits | hw_set) & MASK;
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int          NUM_CTR = 4,
  parameter int          CTR_W   = 32,
  parameter int          HAS_CYC = 1,
  parameter int          FLT_W   = 32,
  parameter logic [31:0] ID_VAL  = 32'h0002_A51C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_CTR-1:0] evt_in,
  output logic               irq_o
);
  localparam bit WIDE  = (CTR_W > 32);
  localparam int TOTAL = NUM_CTR + ((HAS_CYC != 0) ? 1 : 0);
  localparam logic [31:0] CFG_VAL = {17'd0, (HAS_CYC != 0), 6'(CTR_W - 1), 8'(TOTAL - 1)};

  function automatic logic [MAP_W-1:0] impl_mask();
    logic [MAP_W-1:0] m = '0;
    for (int i = 0; i < NUM_CTR; i++) m[i] = 1'b1;
    if (HAS_CYC != 0) m[CYC_IDX] = 1'b1;
    return m;
  endfunction
  localparam logic [MAP_W-1:0] IMPL = impl_mask();

  function automatic logic [31:0] pick_word(input logic [CTR_W-1:0] v, input logic hi);
    logic [63:0] e = 64'(v);
    return hi ? e[63:32] : e[31:0];
  endfunction

  // ---------------- decode ----------------
  logic       wr, rd, ctr_reg, typ_reg, flt_reg, ctr_hi;
  logic [7:0] ctr_idx;
  logic [4:0] cfg_idx;
  ctrl_wr_t   cw;

  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign ctr_reg = (bus_addr[11:10] == 2'b00);
  assign typ_reg = (bus_addr[11:7] == 5'b01000);
  assign flt_reg = (bus_addr[11:7] == 5'b10100);
  assign ctr_idx = WIDE ? {1'b0, bus_addr[9:3]} : bus_addr[9:2];
  assign ctr_hi  = WIDE & bus_addr[2];
  assign cfg_idx = bus_addr[6:2];
  assign cw      = (wr && bus_addr == A_CTRL) ? ctrl_wr_t'(bus_wdata[2:0]) : '0;

  // ---------------- control ----------------
  logic run_q;
  always_ff @(posedge clk) begin
    if (rst)                          run_q <= 1'b0;
    else if (wr && bus_addr == A_CTRL) run_q <= cw.run;
  end

  // ---------------- bitmaps ----------------
  logic [MAP_W-1:0] cnten_q, inten_q, ovf_q, hw_ovf;

  pcb_bitmap #(.W(MAP_W), .MASK(IMPL)) u_cnten (
    .clk(clk), .rst(rst),
    .set_we(wr && bus_addr == A_CNTEN_SET), .clr_we(wr && bus_addr == A_CNTEN_CLR),
    .wdata(bus_wdata), .hw_set('0), .q(cnten_q));

  pcb_bitmap #(.W(MAP_W), .MASK(IMPL)) u_inten (
    .clk(clk), .rst(rst),
    .set_we(wr && bus_addr == A_INTEN_SET), .clr_we(wr && bus_addr == A_INTEN_CLR),
    .wdata(bus_wdata), .hw_set('0), .q(inten_q));

  pcb_bitmap #(.W(MAP_W), .MASK(IMPL)) u_ovf (
    .clk(clk), .rst(rst),
    .set_we(wr && bus_addr == A_OVF_SET), .clr_we(wr && bus_addr == A_OVF_CLR),
    .wdata(bus_wdata), .hw_set(hw_ovf), .q(ovf_q));

  // ---------------- general counters ----------------
  logic [CTR_W-1:0] ev_cnt [NUM_CTR];
  logic [FLT_W-1:0] ev_typ [NUM_CTR];
  logic [FLT_W-1:0] ev_flt [NUM_CTR];
  logic [NUM_CTR-1:0] ev_wrap;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    pcb_counter #(.W(CTR_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(cw.clr_evt),
      .inc(run_q & cnten_q[g] & evt_in[g]),
      .wr_en(wr & ctr_reg & (ctr_idx == 8'(g))),
      .wr_hi(ctr_hi), .wr_data(bus_wdata),
      .cnt(ev_cnt[g]), .wrap(ev_wrap[g]));

    always_ff @(posedge clk) begin
      if (rst) begin
        ev_typ[g] <= '0;
        ev_flt[g] <= '0;
      end else begin
        if (wr && typ_reg && cfg_idx == 5'(g)) ev_typ[g] <= bus_wdata[FLT_W-1:0];
        if (wr && flt_reg && cfg_idx == 5'(g)) ev_flt[g] <= bus_wdata[FLT_W-1:0];
      end
    end
  end

  // ---------------- cycle counter ----------------
  logic [CTR_W-1:0] cyc_cnt;
  logic [FLT_W-1:0] cyc_flt;
  logic             cyc_wrap;

  if (HAS_CYC != 0) begin : g_cyc
    pcb_counter #(.W(CTR_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(cw.clr_cyc),
      .inc(run_q & cnten_q[CYC_IDX]),
      .wr_en(wr & ctr_reg & (ctr_idx == 8'(CYC_IDX))),
      .wr_hi(ctr_hi), .wr_data(bus_wdata),
      .cnt(cyc_cnt), .wrap(cyc_wrap));

    always_ff @(posedge clk) begin
      if (rst)                          cyc_flt <= '0;
      else if (wr && bus_addr == A_CCFILT) cyc_flt <= bus_wdata[FLT_W-1:0];
    end
  end else begin : g_no_cyc
    assign cyc_cnt  = '0;
    assign cyc_flt  = '0;
    assign cyc_wrap = 1'b0;
  end

  always_comb begin
    hw_ovf                = '0;
    hw_ovf[NUM_CTR-1:0]   = ev_wrap;
    hw_ovf[CYC_IDX]       = cyc_wrap;
  end

  // ---------------- interrupt ----------------
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(ovf_q & inten_q);
  end

  // ---------------- read path ----------------
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (ctr_reg) begin
      for (int i = 0; i < NUM_CTR; i++)
        if (ctr_idx == 8'(i)) rd_mux = pick_word(ev_cnt[i], ctr_hi);
      if (HAS_CYC != 0 && ctr_idx == 8'(CYC_IDX)) rd_mux = pick_word(cyc_cnt, ctr_hi);
    end else if (typ_reg) begin
      for (int i = 0; i < NUM_CTR; i++)
        if (cfg_idx == 5'(i)) rd_mux = 32'(ev_typ[i]);
      if (HAS_CYC != 0 && cfg_idx == 5'(CYC_IDX)) rd_mux = 32'(cyc_flt);
    end else if (flt_reg) begin
      for (int i = 0; i < NUM_CTR; i++)
        if (cfg_idx == 5'(i)) rd_mux = 32'(ev_flt[i]);
    end else begin
      case (bus_addr)
        A_CNTEN_SET, A_CNTEN_CLR: rd_mux = cnten_q;
        A_INTEN_SET, A_INTEN_CLR: rd_mux = inten_q;
        A_OVF_CLR,   A_OVF_SET:   rd_mux = ovf_q;
        A_CFG:                    rd_mux = CFG_VAL;
        A_CTRL:                   rd_mux = {31'd0, run_q};
        A_ID:                     rd_mux = ID_VAL;
        default:                  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
  import pcb_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic        bus_rvalid,
  input logic        irq_o,
  input logic [31:0] ovf_q,
  input logic [31:0] inten_q,
  input logic [31:0] cnten_q
);
  // R10: interrupt is the registered OR of enabled overflow flags
  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(ovf_q & inten_q)));

  // R12: read data valid exactly one cycle after a read request
  a_r12_rvalid_on: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> bus_rvalid);
  a_r12_rvalid_off: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> !bus_rvalid);

  // R9: overflow flags only drop after a write to the clear address
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_we && bus_addr == A_OVF_CLR) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R4: count-enable bits only drop after a write to their clear address
  a_r4_cnten_sticky: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_we && bus_addr == A_CNTEN_CLR) |=> ((cnten_q & $past(cnten_q)) == $past(cnten_q)));

  // R11: control reads never return the self-clearing bits
  a_r11_ctrl_rd: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == A_CTRL) |=> (bus_rdata[31:1] == 31'd0));

  // R13: reset leaves interrupt and read-valid low
  a_r13_reset: assert property (@(posedge clk)
    rst |=> (!irq_o && !bus_rvalid));
endmodule

bind perf_counter_bank pcb_checker i_pcb_checker (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_o(irq_o),
  .ovf_q(ovf_q), .inten_q(inten_q), .cnten_q(cnten_q));

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;
  localparam int          NC  = 4;
  localparam int          W   = 32;
  localparam logic [31:0] IDV = 32'h0002_A51C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NC-1:0] evt_in = '0;
  logic          irq_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  perf_counter_bank #(.NUM_CTR(NC), .CTR_W(W), .HAS_CYC(1), .FLT_W(32), .ID_VAL(IDV)) i_perf_counter_bank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .evt_in(evt_in), .irq_o(irq_o));

  function automatic logic [31:0] cfg_expect();
    return (32'd1 << 14) | (32'(W - 1) << 8) | 32'(NC);
  endfunction

  function automatic logic [31:0] impl_expect();
    return 32'h8000_0000 | ((32'd1 << NC) - 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge; each spans one rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, en, t, f;
    int exp_cnt [NC];
    int exp_cyc, k;
    void'($urandom(32'd20240607));

    idle(4);
    rst = 0;

    // R13 reset state
    check("R13 irq", 32'(irq_o), 0);
    check("R13 rvalid", 32'(bus_rvalid), 0);
    for (int i = 0; i < NC; i++) rd_chk("R13 counter", 12'(4 * i), 0);
    rd_chk("R13 cycle counter", 12'h07C, 0);
    rd_chk("R13 ctrl", 12'hE04, 0);
    rd_chk("R13 cnten", 12'hC00, 0);

    // R1, R2 identification
    rd_chk("R1 config", 12'hE00, cfg_expect());
    rd_chk("R2 id", 12'hE08, IDV);

    // R11 reset bits read back as 0
    wr(12'hE04, 32'h7);
    rd_chk("R11 ctrl readback", 12'hE04, 1);
    wr(12'hE04, 0);

    // R3 type and filter registers
    for (int i = 0; i < NC; i++) begin
      t = $urandom; f = $urandom;
      wr(12'(12'h400 + 4 * i), t);
      wr(12'(12'hA00 + 4 * i), f);
      rd_chk("R3 type", 12'(12'h400 + 4 * i), t);
      rd_chk("R3 filter", 12'(12'hA00 + 4 * i), f);
    end
    f = $urandom;
    wr(12'h47C, f);
    rd_chk("R3 cycle filter", 12'h47C, f);
    wr(12'(12'h400 + 4 * NC), 32'hFFFF_FFFF);
    rd_chk("R3 unimplemented type ignored", 12'(12'h400 + 4 * NC), 0);

    // R4 set/clear bitmaps
    wr(12'hC00, 32'hFFFF_FFFF);
    rd_chk("R4 cnten set view", 12'hC00, impl_expect());
    rd_chk("R4 cnten clr view", 12'hC20, impl_expect());
    wr(12'hC20, 32'h2);
    rd_chk("R4 cnten after clr", 12'hC00, impl_expect() & ~32'h2);
    wr(12'hC40, 32'h5);
    rd_chk("R4 inten set", 12'hC60, 32'h5);
    wr(12'hC60, 32'hFFFF_FFFF);
    rd_chk("R4 inten clr", 12'hC40, 0);

    // R12 latency and unmapped read
    bus_sel = 1; bus_we = 0; bus_addr = 12'hD00;
    @(negedge clk);
    bus_sel = 0;
    check("R12 rvalid", 32'(bus_rvalid), 1);
    check("R12 unmapped", bus_rdata, 0);
    idle(1);
    check("R12 rvalid drops", 32'(bus_rvalid), 0);

    // R5 R6 random counting rounds
    for (int r = 0; r < 4; r++) begin
      en = ($urandom & ((32'd1 << NC) - 1)) | ((r % 2 == 0) ? 32'h8000_0000 : 0);
      wr(12'hC20, 32'hFFFF_FFFF);
      wr(12'hC00, en);
      wr(12'hE04, 32'h6);
      for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
      k = 20 + int'($urandom % 30);
      wr(12'hE04, 32'h1);
      for (int c = 0; c < k; c++) begin
        evt_in = NC'($urandom);
        for (int i = 0; i < NC; i++) if (en[i] && evt_in[i]) exp_cnt[i]++;
        @(negedge clk);
      end
      evt_in = '0;
      wr(12'hE04, 0);
      exp_cyc = en[31] ? k + 1 : 0;
      for (int i = 0; i < NC; i++) rd_chk("R5 event count", 12'(4 * i), 32'(exp_cnt[i]));
      rd_chk("R6 cycle count", 12'h07C, 32'(exp_cyc));
      // R5 stopped: events have no effect
      evt_in = '1;
      idle(5);
      evt_in = '0;
      for (int i = 0; i < NC; i++) rd_chk("R5 stopped count", 12'(4 * i), 32'(exp_cnt[i]));
    end

    // R7 counter write/readback
    d = $urandom;
    wr(12'h008, d);
    rd_chk("R7 counter write", 12'h008, d);
    d = $urandom;
    wr(12'h07C, d);
    rd_chk("R7 cycle write", 12'h07C, d);

    // R8 R10 wrap, overflow and interrupt
    wr(12'hC20, 32'hFFFF_FFFF);
    wr(12'hC80, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'hC40, 32'h1);
    wr(12'hC00, 32'h1);
    wr(12'hE04, 32'h1);
    evt_in = 4'b0001;
    @(negedge clk);
    evt_in = '0;
    check("R10 irq not yet", 32'(irq_o), 0);
    idle(1);
    check("R10 irq raised", 32'(irq_o), 1);
    wr(12'hE04, 0);
    rd_chk("R8 wrapped to zero", 12'h000, 0);
    rd_chk("R8 overflow flag", 12'hC80, 32'h1);
    rd_chk("R9 read no side effect", 12'hCC0, 32'h1);
    wr(12'hC80, 32'h1);
    check("R10 irq still high", 32'(irq_o), 1);
    idle(1);
    check("R10 irq cleared", 32'(irq_o), 0);

    // R9 R10 software set, gated by interrupt enable
    wr(12'hCC0, 32'h4);
    rd_chk("R9 ovf set", 12'hC80, 32'h4);
    idle(1);
    check("R10 masked", 32'(irq_o), 0);
    wr(12'hC40, 32'h4);
    idle(1);
    check("R10 unmasked", 32'(irq_o), 1);
    wr(12'hC80, 32'hFFFF_FFFF);
    wr(12'hC60, 32'hFFFF_FFFF);

    // R9 wrap wins over same-cycle clear
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'hC00, 32'h2);
    wr(12'hE04, 32'h1);
    evt_in = 4'b0010;
    wr(12'hC80, 32'h2);
    evt_in = '0;
    wr(12'hE04, 0);
    rd_chk("R9 set wins", 12'hC80, 32'h2);
    wr(12'hC80, 32'hFFFF_FFFF);

    // R11 one-shot clears
    wr(12'h000, 32'h5);
    wr(12'h07C, 32'h9);
    wr(12'hE04, 32'h2);
    rd_chk("R11 event cleared", 12'h000, 0);
    rd_chk("R11 cycle kept", 12'h07C, 32'h9);
    rd_chk("R11 ctrl after clear", 12'hE04, 0);
    wr(12'hE04, 32'h4);
    rd_chk("R11 cycle cleared", 12'h07C, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule